// File: doc/BRIEF.md
# Serial Clock Divider with Programmable Duty

This block derives the serial clock of an SPI master from the system clock. Two dividers sit in series: a prescaler that stretches each system cycle into a sub-cycle of a chosen length, and a sub-cycle counter that sets how many sub-cycles make one serial-clock period. A separate high point inside that count places the falling edge anywhere in the period, so both frequency and duty cycle come straight from field values. Every field holds the wanted count minus one. The serial frequency is f_sys / (pre × n).

For rates close to the system rate, a bypass selection passes the system clock itself to the serial clock pin. The clock rests at a programmable idle level while disabled. It starts a fresh period from the idle level when enabled. It picks up new field values only at period boundaries. Two single-cycle strobes mark the cycle in which the clock enters its active level and the cycle in which it returns to idle. Surrounding logic uses them to sample and launch serial data.

Top module: `sclk_gen`

## Requirements
- R1: During reset and while `enable` is low, `sclk` equals `idlePol`, and `sampleStb` and `launchStb` are low. The one exception is the cycle in which a running clock is stopped (see R9).
- R2: The first rising clock edge that sees `enable` high starts a period. From that edge on, `sclk` is at the active level (the inverse of `idlePol`) and `sampleStb` is high for that cycle.
- R3: In divided mode one period lasts (preField+1)×n system cycles, where n = cntField+1. The first h×(preField+1) cycles of the period are at the active level, with h = highField+1, and the rest are at the idle level.
- R4: `sampleStb` is high for exactly the one cycle in which `sclk` moves from idle to active. `launchStb` is high for exactly the one cycle in which `sclk` moves from active to idle. Outside bypass, the two strobes are never high together.
- R5: Field and bypass inputs are captured only when a period starts. A change in the middle of a period does not alter the rest of that period.
- R6: In divided mode, cntField = 0 is treated as n = 2, so every period has at least one active and one idle sub-cycle.
- R7: A high count h that is not below n is clamped to h = n−1.
- R8: In bypass mode (bypassSel captured high), `sclk` equals `clk` XOR `idlePol`, and both strobes stay high in every cycle. Each system cycle is a period, so a cleared bypassSel takes effect at the next edge.
- R9: Dropping `enable` forces the active level off at the next edge. If `sclk` was active, `launchStb` pulses in that cycle. A later enable starts a new full period as in R2.
- R10: `idlePol` acts on the output at once. High selects an idle-high, active-low clock, and low selects the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the serial clock while high |
| idlePol | input | 1 | Level of the clock while idle |
| bypassSel | input | 1 | Passes the system clock through when captured high |
| preField | input | 13 | Prescale length minus one (1 to 8192 cycles) |
| cntField | input | 6 | Sub-cycles per period minus one (1 to 64) |
| highField | input | 6 | Active sub-cycles per period minus one |
| sclk | output | 1 | Serial clock |
| sampleStb | output | 1 | One-cycle strobe on the idle-to-active transition |
| launchStb | output | 1 | One-cycle strobe on the active-to-idle transition |

## Verification
A prescale or sub-cycle counter that drifts by one moves the next transition of `sclk` and its strobe by at least one system cycle. The bench model compares all three outputs in every cycle, so such an error shows up within one period. A field captured at the wrong moment changes the length of the period in which the change was made, which R5 targets directly. A wrong bypass or idle state flips `sclk` in the very next compared cycle.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef struct packed {
    logic nextActive;
    logic nextBypass;
  } sclkStb_t;
endpackage

// File: rtl/sclk_ctrl.sv
module sclk_ctrl
  import sclk_pkg::*;
#(
  parameter int PRE_W = 13,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bypassSel,
  input  logic [PRE_W-1:0] preField,
  input  logic [CNT_W-1:0] cntField,
  input  logic [CNT_W-1:0] highField,
  output sclkStb_t         stb
);
  localparam logic [CNT_W-1:0] MIN_LAST = CNT_W'(1);

  logic             running, byV;
  logic [PRE_W-1:0] preV, preCnt;
  logic [CNT_W-1:0] nLast, hLast, subCnt;

  logic             tick, periodEnd, start;
  logic [CNT_W-1:0] capN, capH;
  logic             nRun, nBy;
  logic [PRE_W-1:0] nPreV, nPreCnt;
  logic [CNT_W-1:0] nNLast, nHLast, nSub;

  always_comb begin
    tick      = running && (preCnt == preV);
    periodEnd = tick && (subCnt == nLast);
    start     = enable && (!running || byV || periodEnd);
    capN      = (cntField < MIN_LAST) ? MIN_LAST : cntField;
    capH      = (highField >= capN) ? (capN - CNT_W'(1)) : highField;

    nRun    = running;
    nBy     = byV;
    nPreV   = preV;
    nNLast  = nLast;
    nHLast  = hLast;
    nSub    = subCnt;
    nPreCnt = preCnt;
    if (!enable) begin
      nRun    = 1'b0;
      nSub    = '0;
      nPreCnt = '0;
    end else if (start) begin
      nRun    = 1'b1;
      nBy     = bypassSel;
      nPreV   = preField;
      nNLast  = capN;
      nHLast  = capH;
      nSub    = '0;
      nPreCnt = '0;
    end else if (tick) begin
      nPreCnt = '0;
      nSub    = subCnt + CNT_W'(1);
    end else begin
      nPreCnt = preCnt + PRE_W'(1);
    end

    stb.nextActive = nRun && !nBy && (nSub <= nHLast);
    stb.nextBypass = nRun && nBy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      byV     <= 1'b0;
      preV    <= '0;
      nLast   <= MIN_LAST;
      hLast   <= '0;
      subCnt  <= '0;
      preCnt  <= '0;
    end else begin
      running <= nRun;
      byV     <= nBy;
      preV    <= nPreV;
      nLast   <= nNLast;
      hLast   <= nHLast;
      subCnt  <= nSub;
      preCnt  <= nPreCnt;
    end
  end

  a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (preCnt <= preV));
  a_r3_sub_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (subCnt <= nLast));
  a_r6_min_count: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !byV) |-> (nLast >= MIN_LAST));
  a_r7_high_below: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !byV) |-> (hLast < nLast));
  a_r5_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (running && enable && !byV && !periodEnd) |=>
      ($stable(preV) && $stable(nLast) && $stable(hLast)));
  a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !running);
endmodule

// File: rtl/sclk_dp.sv
module sclk_dp
  import sclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     idlePol,
  input  sclkStb_t stb,
  output logic     sclk,
  output logic     sampleStb,
  output logic     launchStb
);
  logic activeQ, bypQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeQ   <= 1'b0;
      bypQ      <= 1'b0;
      sampleStb <= 1'b0;
      launchStb <= 1'b0;
    end else begin
      activeQ   <= stb.nextActive;
      bypQ      <= stb.nextBypass;
      sampleStb <= stb.nextBypass | (stb.nextActive & ~activeQ);
      launchStb <= stb.nextBypass | (~stb.nextActive & activeQ);
    end
  end

  assign sclk = bypQ ? (clk ^ idlePol) : (activeQ ^ idlePol);

  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !bypQ |-> !(sampleStb && launchStb));
  a_r4_sample_active: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && !bypQ) |-> activeQ);
  a_r4_launch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (launchStb && !bypQ) |-> !activeQ);
  a_r8_bypass_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    bypQ |-> (sampleStb && launchStb && !activeQ));
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_pkg::*;
#(
  parameter int PRE_W = 13,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             idlePol,
  input  logic             bypassSel,
  input  logic [PRE_W-1:0] preField,
  input  logic [CNT_W-1:0] cntField,
  input  logic [CNT_W-1:0] highField,
  output logic             sclk,
  output logic             sampleStb,
  output logic             launchStb
);
  sclkStb_t stb;

  sclk_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bypassSel(bypassSel),
    .preField(preField), .cntField(cntField), .highField(highField),
    .stb(stb)
  );

  sclk_dp u_dp (
    .clk(clk), .rst_n(rst_n), .idlePol(idlePol), .stb(stb),
    .sclk(sclk), .sampleStb(sampleStb), .launchStb(launchStb)
  );
endmodule

// File: tb/sclk_gen_test.sv
module sclk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        idlePol = 1'b0;
  logic        bypassSel = 1'b0;
  logic [12:0] preField = '0;
  logic [5:0]  cntField = 6'd3;
  logic [5:0]  highField = 6'd1;
  logic        sclk, sampleStb, launchStb;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  sclk_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .idlePol(idlePol),
    .bypassSel(bypassSel), .preField(preField), .cntField(cntField),
    .highField(highField), .sclk(sclk), .sampleStb(sampleStb),
    .launchStb(launchStb)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int mPre = 1, mN = 2, mH = 1, mPos = 0;
  bit mRun = 0, mByp = 0, mAct = 0, mPrev = 0, mSamp = 0, mLaunch = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mRun = 0; mByp = 0; mAct = 0; mSamp = 0; mLaunch = 0; mPos = 0;
    end else begin
      mPrev = mAct;
      if (!enable) mRun = 0;
      else if (!mRun || mByp || mPos == mPre * mN - 1) begin
        mRun = 1;
        mPre = int'(preField) + 1;
        mN   = (int'(cntField) + 1 < 2) ? 2 : int'(cntField) + 1;
        mH   = (int'(highField) + 1 >= mN) ? mN - 1 : int'(highField) + 1;
        mByp = bypassSel;
        mPos = 0;
      end else mPos++;
      mAct = mRun && !mByp && (mPos < mH * mPre);
      if (mRun && mByp) begin mSamp = 1; mLaunch = 1; end
      else begin mSamp = mAct && !mPrev; mLaunch = !mAct && mPrev; end
    end
  end

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("sclk", sclk, (mRun && mByp) ? idlePol : (mAct ^ idlePol));
    chk("sampleStb", sampleStb, mSamp);
    chk("launchStb", launchStb, mLaunch);
  end

  // R8: high phase of bypass clock
  always @(posedge clk) begin
    #5;
    if (rst_n && mRun && mByp) chk("sclk high phase", sclk, ~idlePol);
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic setF(int p, int c, int h);
    preField = 13'(p); cntField = 6'(c); highField = 6'(h);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    curReq = "R1";
    step(3);
    rst_n = 1'b1;
    step(4);
    curReq = "R2 R3 R4";
    setF(0, 3, 1); enable = 1'b1;
    step(24);
    curReq = "R3";
    setF(2, 4, 0);
    step(50);
    curReq = "R10";
    idlePol = 1'b1;
    step(40);
    curReq = "R5";
    setF(1, 2, 0);
    step(3);
    setF(3, 5, 3);
    step(60);
    curReq = "R6";
    setF(1, 0, 0);
    step(20);
    curReq = "R7";
    idlePol = 1'b0;
    setF(0, 3, 20);
    step(20);
    curReq = "R8";
    bypassSel = 1'b1;
    step(12);
    idlePol = 1'b1;
    step(6);
    bypassSel = 1'b0;
    setF(1, 3, 1);
    step(20);
    curReq = "R9";
    step(3);
    enable = 1'b0;
    step(6);
    enable = 1'b1;
    step(30);
    curReq = "R3 long";
    setF(100, 1, 0);
    step(450);
    curReq = "R1";
    enable = 1'b0;
    step(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule